// File: doc/BRIEF.md
# Receive DMA Channel with Descriptor Ring

This block stores received Ethernet frames in system memory. Memory holds a ring of descriptors. Each descriptor is two 32-bit words: a status word, then a buffer pointer. Software marks a buffer as free by writing a status word with the ownership bit set and the buffer capacity in the length field. The channel takes descriptors in ring order. It reads the status word, and if it owns the descriptor it reads the pointer and then accepts one frame from a byte-wide stream. It packs the frame bytes into 32-bit writes to the buffer. After the last data write is acknowledged, it writes back a completed status that hands the descriptor back to software.

If a descriptor is not owned, the channel reads it again. With polling enabled it waits a programmable number of clocks between reads; with polling disabled it reads again at once. A four-entry write-only register port sets the enable, the channel reset, the ring base, the ring length and the polling interval. Base and length are staged: they only take effect on a channel reset, and a reset is only accepted while the channel is stopped.

The memory port issues one access at a time. A request is held with stable address and data until the cycle in which it is acknowledged.

Top module: `rxdma_chan`

## Requirements
- R1: For ring index i, the status word is read at base+8*i and the pointer at base+8*i+4. Base bits 2:0 and pointer bits 1:0 are ignored.
- R2: A status word with bit 31 clear causes no buffer access. With polling off, the status read is repeated immediately, so acknowledges on a zero-latency memory are 2 cycles apart. With polling on and count N>0, the gap is N+1 cycles.
- R3: Frame byte k goes to bits 8*(k mod 4) of the word at pointer+4*(k div 4). Each write carries one byte-enable bit per stored byte, and the last word of a frame may be partial.
- R4: The completed status is written after the last data write is acknowledged, with byte enable 4'hF. Bit 31=0, bits 30, 29 and 28 = 1, bit 22 = truncation flag, bits 15:0 = stored byte count, all other bits 0.
- R5: Bytes beyond the capacity in status bits 15:0 are accepted but not written. The stored length equals the capacity and bit 22 is set. Nothing spills into the next descriptor.
- R6: Descriptors are used in ring order. The index returns to 0 after the last of the programmed count.
- R7: Register map: address 0 is control (bit 0 enable, bit 1 reset), 1 is base, 2 is count, 3 is polling (bit 31 enable, bits 19:4 interval). Base and count writes take effect only at a reset. A reset written while the channel is running is ignored.
- R8: Clearing the enable stops the channel at a descriptor boundary. While it is stopped, no memory request and no rx_ready is issued.
- R9: A memory request stays asserted, with address, direction and write data unchanged, until mem_ack. Only one access is outstanding at a time.
- R10: While waiting for a frame, bytes without a start marker are consumed and discarded.
- R11: rx_ready is high only while the channel holds an owned descriptor and has no memory access in progress. It is never high together with mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Frame byte valid |
| rx_sop | input | 1 | First byte of frame |
| rx_eop | input | 1 | Last byte of frame |
| rx_byte | input | 8 | Frame byte |
| rx_ready | output | 1 | Channel accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
Two events can coincide. Software may hand a descriptor back to the channel, and the channel's polling timer may expire and re-read that same descriptor. The bench provokes this by setting the ownership bit in its memory model at an arbitrary point while the channel polls. A frame must then land in exactly that buffer, and no write may reach it before ownership is set. The bench also checks that the polling gaps match the programmed interval, and that a reconfiguration written during polling has no effect until a stop and reset.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STAT,
    ST_RD_PTR,
    ST_WAIT,
    ST_ARMED,
    ST_RECV,
    ST_WR_DATA,
    ST_WR_STAT
  } chan_state_e;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LEN_W      = 16;

  // status word fields
  localparam int OWN_BIT   = 31;
  localparam int CMP_BIT   = 30;
  localparam int SOP_BIT   = 29;
  localparam int EOP_BIT   = 28;
  localparam int TRUNC_BIT = 22;

  // register map
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_BASE  = 2'd1;
  localparam logic [1:0] A_COUNT = 2'd2;
  localparam logic [1:0] A_POLL  = 2'd3;
  localparam int CTRL_EN  = 0;
  localparam int CTRL_RST = 1;
  localparam int POLL_EN  = 31;
  localparam int POLL_LSB = 4;

  function automatic logic [WORD_W-1:0] mk_status(input logic trunc,
                                                  input logic [LEN_W-1:0] len);
    logic [WORD_W-1:0] s;
    s            = '0;
    s[CMP_BIT]   = 1'b1;
    s[SOP_BIT]   = 1'b1;
    s[EOP_BIT]   = 1'b1;
    s[TRUNC_BIT] = trunc;
    s[LEN_W-1:0] = len;
    return s;
  endfunction

endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
  import rxdma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 8,
  parameter int PCW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [31:0]     wr_data,
  input  logic            chan_idle,
  output logic            chan_en,
  output logic            chan_reset,
  output logic [AW-1:0]   ring_base,
  output logic [IDXW-1:0] ring_count,
  output logic            poll_on,
  output logic [PCW-1:0]  poll_len
);

  logic            en_q, en_d;
  logic [AW-1:0]   bstage_q, bstage_d, base_q, base_d;
  logic [IDXW-1:0] cstage_q, cstage_d, cnt_q, cnt_d;
  logic            pon_q, pon_d;
  logic [PCW-1:0]  plen_q, plen_d;

  assign chan_reset = wr_en && (wr_addr == A_CTRL) && wr_data[CTRL_RST] && chan_idle;

  always_comb begin
    en_d     = en_q;
    bstage_d = bstage_q;
    cstage_d = cstage_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    pon_d    = pon_q;
    plen_d   = plen_q;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL:  en_d = wr_data[CTRL_EN];
        A_BASE:  bstage_d = {wr_data[AW-1:3], 3'b000};
        A_COUNT: cstage_d = wr_data[IDXW-1:0];
        A_POLL: begin
          pon_d  = wr_data[POLL_EN];
          plen_d = wr_data[POLL_LSB +: PCW];
        end
        default: ;
      endcase
    end
    if (chan_reset) begin
      base_d = bstage_q;
      cnt_d  = cstage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      bstage_q <= '0;
      cstage_q <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      pon_q    <= 1'b0;
      plen_q   <= '0;
    end else begin
      en_q     <= en_d;
      bstage_q <= bstage_d;
      cstage_q <= cstage_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      pon_q    <= pon_d;
      plen_q   <= plen_d;
    end
  end

  assign chan_en    = en_q;
  assign ring_base  = base_q;
  assign ring_count = cnt_q;
  assign poll_on    = pon_q;
  assign poll_len   = plen_q;

endmodule

// File: rtl/rxdma_poll_timer.sv
module rxdma_poll_timer #(
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [PCW-1:0] load_val,
  input  logic           tick,
  output logic           expired
);

  logic [PCW-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (load)
      val_d = load_val;
    else if (tick && (val_q != '0))
      val_d = val_q - PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign expired = (val_q <= PCW'(1));

endmodule

// File: rtl/rxdma_packer.sv
module rxdma_packer #(
  parameter int LANES = 4,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               put,
  input  logic [LW-1:0]      lane,
  input  logic [7:0]         byte_in,
  output logic [8*LANES-1:0] word,
  output logic [LANES-1:0]   be
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] b_q, b_d;
    logic       v_q, v_d;

    always_comb begin
      b_d = b_q;
      v_d = v_q;
      if (clr) begin
        v_d = 1'b0;
      end else if (put && (lane == LW'(g))) begin
        b_d = byte_in;
        v_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= '0;
        v_q <= 1'b0;
      end else begin
        b_q <= b_d;
        v_q <= v_d;
      end
    end

    assign word[8*g +: 8] = b_q;
    assign be[g]          = v_q;
  end

endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan
  import rxdma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 8,
  parameter int PCW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_BYTES-1:0] mem_be,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);

  localparam int LW = $clog2(WORD_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  chan_state_e     state_q, state_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] cap_q, cap_d, stored_q, stored_d;
  logic [AW-1:0]   wptr_q, wptr_d;
  logic            trunc_q, trunc_d, eop_q, eop_d;

  logic            chan_en, chan_reset, poll_on;
  logic [AW-1:0]   ring_base;
  logic [IDXW-1:0] ring_count;
  logic [PCW-1:0]  poll_len;
  logic            tmr_load, tmr_expired;
  logic            pk_clr, pk_put;
  logic [WORD_W-1:0] pk_word;
  logic [WORD_BYTES-1:0] pk_be;

  rxdma_regs #(.AW(AW), .IDXW(IDXW), .PCW(PCW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_ni),
    .wr_en      (cfg_wr),
    .wr_addr    (cfg_addr),
    .wr_data    (cfg_wdata),
    .chan_idle  (state_q == ST_IDLE),
    .chan_en    (chan_en),
    .chan_reset (chan_reset),
    .ring_base  (ring_base),
    .ring_count (ring_count),
    .poll_on    (poll_on),
    .poll_len   (poll_len)
  );

  rxdma_poll_timer #(.PCW(PCW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (tmr_load),
    .load_val (poll_len),
    .tick     (state_q == ST_WAIT),
    .expired  (tmr_expired)
  );

  rxdma_packer #(.LANES(WORD_BYTES)) u_pack (
    .clk     (clk),
    .rst_n   (rst_ni),
    .clr     (pk_clr),
    .put     (pk_put),
    .lane    (stored_q[LW-1:0]),
    .byte_in (rx_byte),
    .word    (pk_word),
    .be      (pk_be)
  );

  // descriptor address and ring index advance
  logic [AW-1:0] desc_addr;
  logic [IDXW:0] idx_inc;
  logic          idx_wrap;
  assign desc_addr = ring_base + (AW'(idx_q) << 3);
  assign idx_inc   = {1'b0, idx_q} + (IDXW+1)'(1);
  assign idx_wrap  = idx_inc >= {1'b0, ring_count};

  // byte intake
  logic take, fits, word_full, pend_after;
  assign rx_ready   = (state_q == ST_ARMED) || (state_q == ST_RECV);
  assign take       = rx_ready && rx_valid && ((state_q == ST_RECV) || rx_sop);
  assign fits       = stored_q < cap_q;
  assign pk_put     = take && fits;
  assign word_full  = pk_put && (stored_q[LW-1:0] == {LW{1'b1}});
  assign pend_after = pk_put || (|pk_be);

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cap_d    = cap_q;
    stored_d = stored_q;
    wptr_d   = wptr_q;
    trunc_d  = trunc_q;
    eop_d    = eop_q;
    tmr_load = 1'b0;
    pk_clr   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (chan_reset)   idx_d = '0;
        else if (chan_en) state_d = ST_RD_STAT;
      end
      ST_RD_STAT: begin
        if (mem_ack) begin
          if (!chan_en) begin
            state_d = ST_IDLE;
          end else if (mem_rdata[OWN_BIT]) begin
            cap_d   = mem_rdata[LEN_W-1:0];
            state_d = ST_RD_PTR;
          end else if (poll_on && (poll_len != '0)) begin
            tmr_load = 1'b1;
            state_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!chan_en)         state_d = ST_IDLE;
        else if (tmr_expired) state_d = ST_RD_STAT;
      end
      ST_RD_PTR: begin
        if (mem_ack) begin
          wptr_d   = {mem_rdata[AW-1:2], 2'b00};
          stored_d = '0;
          trunc_d  = 1'b0;
          eop_d    = 1'b0;
          pk_clr   = 1'b1;
          state_d  = ST_ARMED;
        end
      end
      ST_ARMED, ST_RECV: begin
        if (take) begin
          if (pk_put) stored_d = stored_q + LEN_W'(1);
          else        trunc_d  = 1'b1;
          if (rx_eop) begin
            eop_d   = 1'b1;
            state_d = pend_after ? ST_WR_DATA : ST_WR_STAT;
          end else if (word_full) begin
            state_d = ST_WR_DATA;
          end else begin
            state_d = ST_RECV;
          end
        end else if ((state_q == ST_ARMED) && !chan_en) begin
          state_d = ST_IDLE;
        end
      end
      ST_WR_DATA: begin
        if (mem_ack) begin
          wptr_d  = wptr_q + AW'(WORD_BYTES);
          pk_clr  = 1'b1;
          state_d = eop_q ? ST_WR_STAT : ST_RECV;
        end
      end
      ST_WR_STAT: begin
        if (mem_ack) begin
          idx_d   = idx_wrap ? '0 : idx_inc[IDXW-1:0];
          state_d = chan_en ? ST_RD_STAT : ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      cap_q    <= '0;
      stored_q <= '0;
      wptr_q   <= '0;
      trunc_q  <= 1'b0;
      eop_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      cap_q    <= cap_d;
      stored_q <= stored_d;
      wptr_q   <= wptr_d;
      trunc_q  <= trunc_d;
      eop_q    <= eop_d;
    end
  end

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    mem_be    = '1;
    case (state_q)
      ST_RD_STAT: mem_req = 1'b1;
      ST_RD_PTR: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(4);
      end
      ST_WR_DATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = wptr_q;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      ST_WR_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = mk_status(trunc_q, stored_q);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rxdma_chan_chk.sv
module rxdma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [3:0]    mem_be,
  input logic          mem_ack
);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req);

  p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata) && $stable(mem_be));

  p_addr_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_be_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));

  p_ready_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mem_req);

endmodule

bind rxdma_chan rxdma_chan_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_ready  (rx_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_be    (mem_be),
  .mem_ack   (mem_ack)
);

// File: tb/tb_rxdma_chan.sv
`timescale 1ns/1ps
module tb_rxdma_chan;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        rx_valid, rx_sop, rx_eop;
  logic [7:0]  rx_byte;
  logic        rx_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        mem_ack;

  always #2.5 clk = ~clk;

  rxdma_chan dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural memory and expectation model
  logic [31:0] mem [int unsigned];
  logic [31:0] exp_addr[$], exp_data[$];
  logic [3:0]  exp_be[$];
  string       exp_tag[$];
  logic [7:0]  fbytes[$];
  int          ack_cyc[$];
  int          cyc = 0, mem_lat = 0, wait_cnt = 0;
  logic [31:0] watch_addr = 32'hFFFF_FFFC;
  bit          quiet = 0;
  int          quiet_viol = 0;
  int unsigned bbase, bcount, bidx;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
  endfunction

  function automatic logic [31:0] bemask(input logic [3:0] be);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) if (be[k]) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (quiet && mem_req) quiet_viol++;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && rst_n) begin
        if (wait_cnt < mem_lat) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          mem_ack  = 1'b1;
          if (mem_we) begin
            if (exp_addr.size() == 0) begin
              chk(0, "R3", "unexpected write", mem_addr, 32'h0);
            end else begin
              logic [31:0] ea, ed; logic [3:0] eb; string t;
              ea = exp_addr.pop_front(); ed = exp_data.pop_front();
              eb = exp_be.pop_front();   t  = exp_tag.pop_front();
              chk(mem_addr == ea, t, "write address", mem_addr, ea);
              chk(mem_be == eb, t, "byte enables", {28'h0, mem_be}, {28'h0, eb});
              chk((mem_wdata & bemask(eb)) == (ed & bemask(eb)), t, "write data",
                  mem_wdata & bemask(eb), ed & bemask(eb));
            end
            mem[mem_addr >> 2] = (rd(mem_addr) & ~bemask(mem_be)) | (mem_wdata & bemask(mem_be));
          end else begin
            mem_rdata = rd(mem_addr);
            if (mem_addr == watch_addr) ack_cyc.push_back(cyc);
          end
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic arm_desc(input int unsigned base, input int unsigned i,
                          input logic [31:0] ptr, input logic [15:0] cap);
    mem[(base + 8*i) >> 2]     = {1'b1, 15'h0, cap};
    mem[(base + 8*i + 4) >> 2] = ptr;
  endtask

  function automatic void gen_bytes(input int n, input int seed);
    fbytes.delete();
    for (int i = 0; i < n; i++) fbytes.push_back(8'((seed + i*37) & 8'hFF));
  endfunction

  // expected writes for the frame in fbytes (R3, R4, R5) and ring advance (R6)
  function automatic void expect_frame(input logic [31:0] ptr, input int cap, input string tag);
    int n = fbytes.size();
    int stored = (n < cap) ? n : cap;
    bit tr = (n > cap);
    for (int w = 0; w < (stored + 3) / 4; w++) begin
      logic [31:0] d = '0; logic [3:0] b = '0;
      for (int k = 0; k < 4; k++) begin
        if (4*w + k < stored) begin d[8*k +: 8] = fbytes[4*w + k]; b[k] = 1'b1; end
      end
      exp_addr.push_back((ptr & 32'hFFFF_FFFC) + 4*w); exp_data.push_back(d);
      exp_be.push_back(b); exp_tag.push_back(tag);
    end
    exp_addr.push_back(bbase + 8*bidx);
    exp_data.push_back({4'b0111, 5'b0, tr, 6'b0, 16'(stored)});
    exp_be.push_back(4'hF); exp_tag.push_back(tag);
    bidx = (bidx + 1 >= bcount) ? 0 : bidx + 1;
  endfunction

  task automatic send_bytes(input bit with_sop);
    for (int i = 0; i < fbytes.size(); i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sop = with_sop && (i == 0);
      rx_eop = (i == fbytes.size() - 1); rx_byte = fbytes[i];
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (exp_addr.size() != 0 && t < 4000) begin @(negedge clk); t++; end
    chk(exp_addr.size() == 0, tag, "writes outstanding", exp_addr.size(), 0);
  endtask

  task automatic check_gaps(input int expgap, input string tag);
    ack_cyc.delete();
    repeat (8 * expgap + 20) @(negedge clk);
    chk(ack_cyc.size() >= 4, tag, "poll reads seen", ack_cyc.size(), 4);
    for (int i = 1; i < 4 && i < ack_cyc.size(); i++)
      chk(ack_cyc[i] - ack_cyc[i-1] == expgap, tag, "status re-read gap",
          ack_cyc[i] - ack_cyc[i-1], expgap);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_byte = '0;
    repeat (4) @(negedge clk);
    chk(rx_ready == 1'b0, "R11", "rx_ready in reset", rx_ready, 0);
    chk(mem_req == 1'b0, "R8", "mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(mem_req == 1'b0 && rx_ready == 1'b0, "R8", "quiet before enable", {mem_req, rx_ready}, 0);

    // ring A: base 0x1000 (low bits ignored, R1), three descriptors
    bbase = 32'h1000; bcount = 3; bidx = 0;
    arm_desc(bbase, 0, 32'h2000, 16'd64);
    arm_desc(bbase, 1, 32'h2101, 16'd64);  // pointer low bits ignored, R1
    arm_desc(bbase, 2, 32'h2200, 16'd64);
    cfg_write(2'd1, 32'h1005);
    cfg_write(2'd2, 32'd3);
    cfg_write(2'd3, 32'h0);
    cfg_write(2'd0, 32'h3);

    gen_bytes(10, 3);  expect_frame(32'h2000, 64, "R1"); send_bytes(1); drain("R1");
    gen_bytes(8, 50);  expect_frame(32'h2100, 64, "R3"); send_bytes(1); drain("R3");
    gen_bytes(1, 90);  expect_frame(32'h2200, 64, "R4"); send_bytes(1); drain("R4");

    // desc0 now completed, not owned: immediate re-read without polling (R2)
    watch_addr = bbase;
    check_gaps(2, "R2");
    arm_desc(bbase, 0, 32'h2300, 16'd6);
    gen_bytes(9, 7);   expect_frame(32'h2300, 6, "R5"); send_bytes(1); drain("R6");

    // stray bytes without a start marker are dropped (R10)
    arm_desc(bbase, 1, 32'h2400, 16'd64);
    repeat (20) @(negedge clk);
    gen_bytes(3, 200); send_bytes(0);
    repeat (10) @(negedge clk);
    chk(exp_addr.size() == 0, "R10", "no write from stray bytes", exp_addr.size(), 0);
    gen_bytes(5, 11);  expect_frame(32'h2400, 64, "R10"); send_bytes(1); drain("R10");

    // polling interval 5 on a non-owned descriptor (R2), then hand it over mid-poll
    cfg_write(2'd3, 32'h8000_0000 | (32'd5 << 4));
    repeat (10) @(negedge clk);
    watch_addr = bbase + 16;
    check_gaps(6, "R2");
    repeat (3) @(negedge clk);
    arm_desc(bbase, 2, 32'h2500, 16'd64);
    gen_bytes(6, 61);  expect_frame(32'h2500, 64, "R2"); send_bytes(1); drain("R2");

    // reconfiguration while running has no effect (R7)
    cfg_write(2'd1, 32'h5000);
    cfg_write(2'd2, 32'd2);
    cfg_write(2'd0, 32'h3);
    arm_desc(bbase, 0, 32'h2600, 16'd64);
    gen_bytes(7, 99);  expect_frame(32'h2600, 64, "R7"); send_bytes(1); drain("R7");
    arm_desc(bbase, 1, 32'h2700, 16'd64);
    gen_bytes(4, 17);  expect_frame(32'h2700, 64, "R7"); send_bytes(1); drain("R7");

    // stop: no requests, no ready (R8)
    cfg_write(2'd0, 32'h0);
    repeat (12) @(negedge clk);
    quiet = 1; quiet_viol = 0;
    repeat (40) @(negedge clk);
    quiet = 0;
    chk(quiet_viol == 0, "R8", "requests while stopped", quiet_viol, 0);
    chk(rx_ready == 1'b0, "R11", "rx_ready while stopped", rx_ready, 0);

    // reset while stopped loads ring B, index 0; slow memory (R9)
    cfg_write(2'd0, 32'h2);
    bbase = 32'h5000; bcount = 2; bidx = 0;
    arm_desc(bbase, 0, 32'h6000, 16'd64);
    arm_desc(bbase, 1, 32'h6100, 16'd64);
    mem_lat = 2;
    cfg_write(2'd0, 32'h1);
    gen_bytes(13, 5);  expect_frame(32'h6000, 64, "R9"); send_bytes(1); drain("R9");
    gen_bytes(4, 33);  expect_frame(32'h6100, 64, "R9"); send_bytes(1); drain("R9");
    arm_desc(bbase, 0, 32'h6200, 16'd3);
    gen_bytes(6, 77);  expect_frame(32'h6200, 3, "R6"); send_bytes(1); drain("R6");
    chk(rd(32'h5000) == 32'h7040_0003, "R5", "truncated status in memory", rd(32'h5000), 32'h7040_0003);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule